// File: doc/BRIEF.md
# Path Status Remote Defect Codec

This block handles the three-bit remote defect field carried in the path status overhead byte of a SONET path, in both directions. On the transmit side it watches two local path defect flags and produces the enhanced remote defect code that the frame builder inserts into the outgoing status byte. The code is registered and is updated only on a per-frame strobe. Server defects (AIS-P or LOP-P) outrank payload defects (PLM-P or LCD-P).

On the receive side it takes the received status byte together with a per-frame valid strobe. It extracts the remote defect field from byte bits 3 down to 1, with bit 1 as the LSB. Each received code is sorted into a server, payload or connectivity class. Each class has its own persistence filter: a condition is declared after ten contiguous valid frames that carry its code, and released after ten contiguous valid frames that do not. Older plain remote-defect codes are folded into the server class. The no-defect codes count toward release in every class.

Top module: `g1_rdi_codec`

## Requirements
- R1: After reset, tx_code is 001 and rem_server_def, rem_payload_def and rem_conn_def are all 0.
- R2: On a clock edge with frame_stb high and loc_server_def high, tx_code becomes 101 whatever loc_payload_def is.
- R3: On a clock edge with frame_stb high, loc_server_def low and loc_payload_def high, tx_code becomes 010.
- R4: On a clock edge with frame_stb high and both local flags low, tx_code becomes 001; tx_code only ever takes the values 001, 010 or 101.
- R5: tx_code changes only on clock edges where frame_stb is high; it holds its value on all other edges.
- R6: The received code is rx_g1[3:1] (rx_g1[1] is the LSB). rem_server_def rises after ten contiguous valid frames with code 100, 101 or 111, in any mix; a run of nine followed by another code does not declare it.
- R7: A set rem_server_def falls after ten contiguous valid frames with a code other than 100, 101 or 111, and stays set if that run is cut short by a server code.
- R8: rem_payload_def rises after ten contiguous valid frames with code 010 and falls after ten contiguous valid frames with any other code.
- R9: rem_conn_def rises after ten contiguous valid frames with code 110 and falls after ten contiguous valid frames with any other code; code 110 never sets the server or payload flag.
- R10: Codes 000, 001 and 011 set no remote flag and count as release frames for every class.
- R11: Clock edges with rx_valid low neither advance nor break a run, and leave all remote flags unchanged; rx_g1 bits 7:4 and 0 have no effect.
- R12: At most one of the three remote flags is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | Transmit frame strobe; the code is updated on edges where it is high |
| loc_server_def | input | 1 | Local AIS-P or LOP-P defect present |
| loc_payload_def | input | 1 | Local PLM-P or LCD-P defect present |
| tx_code | output | 3 | Remote defect code to insert in the outgoing status byte |
| rx_valid | input | 1 | Received status byte valid, one pulse per frame |
| rx_g1 | input | 8 | Received path status byte |
| rem_server_def | output | 1 | Remote server defect declared |
| rem_payload_def | output | 1 | Remote payload defect declared |
| rem_conn_def | output | 1 | Remote connectivity defect declared |

## Verification
On every cycle, the assertions check the following: the transmit code stays within its three legal values; it holds between frame strobes; it follows the priority rule on each strobe; and every rise or fall of a remote flag happens on a valid frame whose code matches the direction of the change. They also check that idle frames freeze the flags and that the three flags are never set together. Only the bench scenarios can show the ten-frame counting itself. These cover runs of nine that are cut short, mixed legacy server codes that still make one run, idle gaps inside a run, and a release run that is broken and restarted. The bench compares all outputs with a behavioural model on every clock.

// File: rtl/g1_codec_pkg.sv
package g1_codec_pkg;

    typedef logic [2:0] rdi_code_t;

    localparam rdi_code_t CODE_NONE    = 3'b001;
    localparam rdi_code_t CODE_PAYLOAD = 3'b010;
    localparam rdi_code_t CODE_SERVER  = 3'b101;
    localparam rdi_code_t CODE_CONN    = 3'b110;

    localparam int NUM_CLS   = 3;
    localparam int CLS_SRV   = 0;
    localparam int CLS_PAY   = 1;
    localparam int CLS_CONN  = 2;

    // Field position inside the status byte
    localparam int FIELD_LSB = 1;
    localparam int FIELD_MSB = 3;

    function automatic logic [NUM_CLS-1:0] classify(input rdi_code_t code);
        logic [NUM_CLS-1:0] hit;
        hit = '0;
        unique case (code)
            3'b100, 3'b101, 3'b111: hit[CLS_SRV]  = 1'b1;
            3'b010:                 hit[CLS_PAY]  = 1'b1;
            3'b110:                 hit[CLS_CONN] = 1'b1;
            default:                hit = '0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/g1_tx_encoder.sv
module g1_tx_encoder
    import g1_codec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_stb,
    input  logic      loc_server_def,
    input  logic      loc_payload_def,
    output rdi_code_t tx_code
);

    typedef struct packed {
        rdi_code_t code;
    } enc_state_t;

    enc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_stb) begin
            if (loc_server_def) begin
                st_d.code = CODE_SERVER;
            end else if (loc_payload_def) begin
                st_d.code = CODE_PAYLOAD;
            end else begin
                st_d.code = CODE_NONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= CODE_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_code = st_q.code;

endmodule

// File: rtl/g1_rx_classifier.sv
module g1_rx_classifier
    import g1_codec_pkg::*;
(
    input  logic [7:0]         g1_byte,
    output logic [NUM_CLS-1:0] cls_hit
);

    rdi_code_t field;

    always_comb begin
        field   = g1_byte[FIELD_MSB:FIELD_LSB];
        cls_hit = classify(field);
    end

endmodule

// File: rtl/g1_persist_filter.sv
module g1_persist_filter #(
    parameter int PERSIST = 10,
    localparam int CNT_W  = $clog2(PERSIST + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic hit,
    output logic defect
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERSIST - 1);

    typedef struct packed {
        logic             def;
        logic [CNT_W-1:0] cnt;
    } flt_state_t;

    flt_state_t st_d, st_q;
    logic       toward_change;

    always_comb begin
        st_d = st_q;
        // A frame pushes toward a change when it disagrees with the current state
        toward_change = st_q.def ? !hit : hit;
        if (step) begin
            if (toward_change) begin
                if (st_q.cnt == LAST) begin
                    st_d.def = !st_q.def;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign defect = st_q.def;

endmodule

// File: rtl/g1_rdi_codec.sv
module g1_rdi_codec
    import g1_codec_pkg::*;
#(
    parameter int PERSIST = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_stb,
    input  logic       loc_server_def,
    input  logic       loc_payload_def,
    output logic [2:0] tx_code,
    input  logic       rx_valid,
    input  logic [7:0] rx_g1,
    output logic       rem_server_def,
    output logic       rem_payload_def,
    output logic       rem_conn_def
);

    logic [NUM_CLS-1:0] cls_hit;
    logic [NUM_CLS-1:0] cls_def;

    g1_tx_encoder u_enc (
        .clk             (clk),
        .rst_n           (rst_n),
        .frame_stb       (frame_stb),
        .loc_server_def  (loc_server_def),
        .loc_payload_def (loc_payload_def),
        .tx_code         (tx_code)
    );

    g1_rx_classifier u_cls (
        .g1_byte (rx_g1),
        .cls_hit (cls_hit)
    );

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_flt
        g1_persist_filter #(
            .PERSIST (PERSIST)
        ) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .step   (rx_valid),
            .hit    (cls_hit[c]),
            .defect (cls_def[c])
        );
    end

    assign rem_server_def  = cls_def[CLS_SRV];
    assign rem_payload_def = cls_def[CLS_PAY];
    assign rem_conn_def    = cls_def[CLS_CONN];

endmodule

// File: rtl/g1_rdi_codec_chk.sv
module g1_rdi_codec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_stb,
    input logic       loc_server_def,
    input logic       loc_payload_def,
    input logic [2:0] tx_code,
    input logic       rx_valid,
    input logic [7:0] rx_g1,
    input logic       rem_server_def,
    input logic       rem_payload_def,
    input logic       rem_conn_def
);

    logic srv_code;
    assign srv_code = (rx_g1[3:1] == 3'b100) || (rx_g1[3:1] == 3'b101) ||
                      (rx_g1[3:1] == 3'b111);

    assert_tx_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_code == 3'b001) || (tx_code == 3'b010) || (tx_code == 3'b101));

    assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(tx_code));

    assert_tx_server_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && loc_server_def) |=> (tx_code == 3'b101));

    assert_tx_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && !loc_server_def && loc_payload_def) |=> (tx_code == 3'b010));

    assert_srv_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !srv_code) |=> !$rose(rem_server_def));

    assert_srv_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && srv_code) |=> !$fell(rem_server_def));

    assert_pay_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (rx_g1[3:1] == 3'b010)) |=> !$fell(rem_payload_def));

    assert_conn_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (rx_g1[3:1] != 3'b110)) |=> !$rose(rem_conn_def));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable({rem_server_def, rem_payload_def, rem_conn_def}));

    assert_one_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rem_server_def, rem_payload_def, rem_conn_def}));

endmodule

bind g1_rdi_codec g1_rdi_codec_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .frame_stb       (frame_stb),
    .loc_server_def  (loc_server_def),
    .loc_payload_def (loc_payload_def),
    .tx_code         (tx_code),
    .rx_valid        (rx_valid),
    .rx_g1           (rx_g1),
    .rem_server_def  (rem_server_def),
    .rem_payload_def (rem_payload_def),
    .rem_conn_def    (rem_conn_def)
);

// File: tb/g1_rdi_codec_tb.sv
`timescale 1ns/1ps
module g1_rdi_codec_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic       loc_server_def = 1'b0;
    logic       loc_payload_def = 1'b0;
    logic [2:0] tx_code;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_g1 = 8'h00;
    logic       rem_server_def, rem_payload_def, rem_conn_def;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    always #2.5 clk = ~clk;

    g1_rdi_codec u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .frame_stb       (frame_stb),
        .loc_server_def  (loc_server_def),
        .loc_payload_def (loc_payload_def),
        .tx_code         (tx_code),
        .rx_valid        (rx_valid),
        .rx_g1           (rx_g1),
        .rem_server_def  (rem_server_def),
        .rem_payload_def (rem_payload_def),
        .rem_conn_def    (rem_conn_def)
    );

    // Behavioural reference model
    int m_tx;
    int m_run [3];
    bit m_def [3];

    function automatic bit code_in_class(int cls, int code);
        case (cls)
            0: return (code == 4) || (code == 5) || (code == 7);
            1: return code == 2;
            default: return code == 6;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tx = 1;
            for (int c = 0; c < 3; c++) begin
                m_run[c] = 0;
                m_def[c] = 1'b0;
            end
        end else begin
            if (frame_stb) m_tx = loc_server_def ? 5 : (loc_payload_def ? 2 : 1);
            if (rx_valid) begin
                for (int c = 0; c < 3; c++) begin
                    bit inc;
                    inc = code_in_class(c, int'(rx_g1[3:1]));
                    if (inc != m_def[c]) begin
                        m_run[c]++;
                        if (m_run[c] == 10) begin
                            m_def[c] = ~m_def[c];
                            m_run[c] = 0;
                        end
                    end else begin
                        m_run[c] = 0;
                    end
                end
            end
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison with the model
    always @(negedge clk) begin
        if (live) begin
            check(int'(tx_code) == m_tx, "R4 tx_code vs model", int'(tx_code), m_tx);
            check(rem_server_def == m_def[0], "R6 server flag vs model",
                  int'(rem_server_def), int'(m_def[0]));
            check(rem_payload_def == m_def[1], "R8 payload flag vs model",
                  int'(rem_payload_def), int'(m_def[1]));
            check(rem_conn_def == m_def[2], "R9 conn flag vs model",
                  int'(rem_conn_def), int'(m_def[2]));
        end
    end

    // Drive n valid frames carrying code; other byte bits scrambled (R11)
    task automatic send(int code, int n);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_g1 = {4'($urandom), 3'(code), 1'($urandom)};
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_g1 = 8'($urandom);
    endtask

    task automatic idle(int n);
        rx_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            rx_g1 = 8'($urandom);
            @(negedge clk);
        end
    endtask

    task automatic flags(string tag, bit s, bit p, bit c);
        check({rem_server_def, rem_payload_def, rem_conn_def} == {s, p, c}, tag,
              int'({rem_server_def, rem_payload_def, rem_conn_def}), int'({s, p, c}));
    endtask

    task automatic tx_step(bit srv, bit pay, int exp, string tag);
        loc_server_def = srv;
        loc_payload_def = pay;
        @(negedge clk);
        check(int'(tx_code) != exp || exp == 1, "R5 tx held before strobe", int'(tx_code), exp);
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        check(int'(tx_code) == exp, tag, int'(tx_code), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(tx_code == 3'b001, "R1 reset tx_code", int'(tx_code), 1);
        flags("R1 reset flags", 0, 0, 0);
        rst_n = 1'b1;
        live = 1'b1;
        @(negedge clk);

        // Transmit side
        tx_step(1, 0, 5, "R2 server code");
        tx_step(0, 1, 2, "R3 payload code");
        tx_step(1, 1, 5, "R2 server over payload");
        tx_step(0, 0, 1, "R4 no defect code");
        loc_payload_def = 1'b1;
        repeat (4) @(negedge clk);
        check(tx_code == 3'b001, "R5 no strobe no change", int'(tx_code), 1);
        loc_payload_def = 1'b0;

        // Server class: nine then break, then mixed legacy codes
        send(5, 9); send(1, 1);
        flags("R6 nine frames do not declare", 0, 0, 0);
        send(4, 3); send(7, 3); idle(5); send(5, 3);
        flags("R6 nine mixed frames with gap", 0, 0, 0);
        send(7, 1);
        flags("R6 tenth server frame declares R11 gap", 1, 0, 0);
        send(0, 9); send(5, 1); send(3, 9);
        flags("R7 broken release run keeps flag", 1, 0, 0);
        send(1, 1);
        flags("R7 release after ten", 0, 0, 0);

        // Payload class
        send(2, 10);
        flags("R8 payload declared", 0, 1, 0);
        send(1, 9);
        flags("R8 payload still set", 0, 1, 0);
        send(6, 1);
        flags("R8 payload released", 0, 0, 0);

        // Connectivity class
        send(6, 10);
        flags("R9 conn declared only", 0, 0, 1);
        send(2, 10);
        flags("R12 conn released as payload declared", 0, 1, 0);
        send(5, 10);
        flags("R12 payload released as server declared", 1, 0, 0);
        send(3, 10);
        flags("R10 code 011 releases", 0, 0, 0);

        // No-defect codes never declare
        for (int k = 0; k < 3; k++) begin
            send(k == 0 ? 0 : (k == 1 ? 1 : 3), 12);
            flags("R10 no-defect code", 0, 0, 0);
        end

        // Idle frames hold a declared flag
        send(6, 10); idle(30);
        flags("R11 idle keeps flag", 0, 0, 1);
        send(0, 10);

        // Pseudo-random soak compared against the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            frame_stb = ($urandom_range(0, 3) == 0);
            loc_server_def = ($urandom_range(0, 5) == 0);
            loc_payload_def = ($urandom_range(0, 2) == 0);
            if (r < 70) send(int'($urandom_range(0, 7)) % (r < 35 ? 8 : 1) + (r < 35 ? 0 : 2 * (r % 3) + (r % 3 == 2 ? 0 : 0)), int'($urandom_range(1, 14)));
            else idle(1);
        end
        frame_stb = 1'b0;
        idle(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule